// File: doc/BRIEF.md
# Warm-Reset Recovery Sequencer

This block steers a processor core through recovery from a warm reset that the system requests while the core is running. It runs on the fast core clock. It observes two asynchronous inputs, a slow framing clock and an active-high recovery request, through synchronizers of its own. When the request arrives, the block forces a small set of control registers to fixed recovery values. It captures an approximate return address from the current program counter and leaves the exception base register untouched. No self-test is performed on this path.

The system then releases the request twice. The first release is honoured only after the request has stayed high across at least one framing-clock rising edge. After that release the block waits a fixed number of core cycles and expects the request to come back. The second release starts a capture window, followed by two waits aligned to the framing clock. A forwarding-initialisation window spanning three framing edges follows, and then a quiet gap before the first command. The sequence ends with a one-cycle fetch-start pulse. It carries the fetch address, which is the preserved base plus a fixed vector offset. A new request raised during any timed window restarts recovery from the beginning.

Top module: `fault_rst_seq`

## Requirements
- R1: After `rst_n` is released, `busy`, `fwd_init`, `fetch_start`, `fp_en` and `icache_en` are 0, `bcache_on` is 1, and `exc_addr` and `fetch_addr` are 0.
- R2: A request seen while idle (through a 2-flop synchronizer) raises `busy`. In the same cycle `icache_en` becomes 2'b11, `fp_en` becomes 1, `bcache_on` becomes 0, and `exc_addr` takes `pc_in` with bits [1:0] cleared.
- R3: The base register written through `base_we`/`base_wd` is never altered by the recovery sequence. `fetch_addr` equals that base plus 0x780.
- R4: A first release of the request is ignored, and the block stays busy with no progress, unless a framing-clock rising edge was seen while the request was high.
- R5: After the first valid release the block waits DLY_A (264) core cycles and then waits for the request to return. The following release opens a DLY_B (525) cycle capture window.
- R6: After capture the block waits for a framing rising edge plus 2 core cycles, then for the next framing rising edge. `fwd_init` is then high until the third framing rising edge, which is 30 core cycles for a 10-cycle framing period.
- R7: When `fwd_init` falls, DLY_G (264) core cycles pass before `fetch_start` is raised. `busy` falls in that same cycle.
- R8: A request raised during any timed window (DLY_A, capture, framing waits, forwarding window or the command gap) returns the block to the recovery-entry state. The recovery register values and `exc_addr` are applied again there.
- R9: `fetch_start` is high for exactly one cycle per completed sequence, and `fetch_addr` holds its value until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core | input | 1 | Core clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| frame_clk | input | 1 | Slow framing clock, asynchronous to clk_core |
| rst_req | input | 1 | Warm recovery request, active high, asynchronous |
| pc_in | input | 64 | Current program counter |
| base_we | input | 1 | Write enable for the exception base register |
| base_wd | input | 64 | Write data for the exception base register |
| busy | output | 1 | High while a recovery sequence is in progress |
| fwd_init | output | 1 | High during the forwarding-initialisation window |
| icache_en | output | 2 | Instruction-cache enable field |
| fp_en | output | 1 | Floating-point enable bit |
| bcache_on | output | 1 | Board-level cache enabled (cleared by recovery) |
| exc_addr | output | 64 | Captured return address |
| fetch_start | output | 1 | One-cycle pulse starting instruction fetch |
| fetch_addr | output | 64 | Fetch address, valid with and held after fetch_start |

## Verification
The hardest cases to reach are the restarts from deep inside the sequence. Examples are a new request arriving during the forwarding window, or a first release that is too short to count. Both depend on where the request falls relative to the framing clock and to internal counters that the ports do not show. The stimulus drives the framing clock from the same core-clock falling edges as the request. It aligns the short pulse to a framing-clock fall, so that no framing rising edge can fall inside it. It waits for `fwd_init` to rise before raising the abort request. A cycle-accurate behavioural model compares every output on every clock, so any shift in a window's length is caught.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [3:0] {
    ST_RUN      = 4'd0,
    ST_WFAULT   = 4'd1,
    ST_CF1_DLY  = 4'd2,
    ST_CF1_ARM  = 4'd3,
    ST_CF2_HOLD = 4'd4,
    ST_CAPT     = 4'd5,
    ST_SYNC_C   = 4'd6,
    ST_ALIGN    = 4'd7,
    ST_FWD_INIT = 4'd8,
    ST_CMD_GAP  = 4'd9
  } frs_state_e;

  localparam int unsigned SYNC_C_LAST = 2;

  function automatic logic frs_is_timed(input frs_state_e s);
    case (s)
      ST_CF1_DLY, ST_CAPT, ST_SYNC_C, ST_ALIGN, ST_FWD_INIT, ST_CMD_GAP: frs_is_timed = 1'b1;
      default: frs_is_timed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/frs_rst_sync.sv
module frs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/frs_sync.sv
module frs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= 1'b0;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= 1'b0;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/frs_edge.sv
module frs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic lvl;
  logic lvl_d_q;

  frs_sync #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (d),
    .q    (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d_q <= 1'b0;
    else        lvl_d_q <= lvl;
  end

  assign rise = lvl & ~lvl_d_q;
endmodule

// File: rtl/frs_fsm.sv
module frs_fsm
  import frs_pkg::*;
#(
  parameter int DLY_A    = 264,
  parameter int DLY_B    = 525,
  parameter int DLY_G    = 264,
  parameter int FWD_EDGS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       frame_rise,
  output frs_state_e st,
  output logic       enter_wf,
  output logic       fetch_go
);
  localparam int DMAX = (DLY_A > DLY_B) ? ((DLY_A > DLY_G) ? DLY_A : DLY_G)
                                        : ((DLY_B > DLY_G) ? DLY_B : DLY_G);
  localparam int CW = (DMAX > 4) ? $clog2(DMAX + 1) : 3;
  localparam int EW = $clog2(FWD_EDGS + 1);
  localparam logic [CW-1:0] A_LAST = CW'(DLY_A - 1);
  localparam logic [CW-1:0] B_LAST = CW'(DLY_B - 1);
  localparam logic [CW-1:0] G_LAST = CW'(DLY_G - 1);
  localparam logic [CW-1:0] C_LAST = CW'(SYNC_C_LAST);
  localparam logic [EW-1:0] E_LAST = EW'(FWD_EDGS - 1);

  frs_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [EW-1:0] ecnt_q, ecnt_n;
  logic          held_q, held_n;
  logic          st_chg;

  always_comb begin
    st_n     = st_q;
    fetch_go = 1'b0;
    if (req_s && frs_is_timed(st_q)) begin
      st_n = ST_WFAULT;
    end else begin
      case (st_q)
        ST_RUN:      if (req_s) st_n = ST_WFAULT;
        ST_WFAULT:   if (!req_s && held_q) st_n = ST_CF1_DLY;
        ST_CF1_DLY:  if (cnt_q == A_LAST) st_n = ST_CF1_ARM;
        ST_CF1_ARM:  if (req_s) st_n = ST_CF2_HOLD;
        ST_CF2_HOLD: if (!req_s) st_n = ST_CAPT;
        ST_CAPT:     if (cnt_q == B_LAST) st_n = ST_SYNC_C;
        ST_SYNC_C:   if (cnt_q == C_LAST) st_n = ST_ALIGN;
        ST_ALIGN:    if (frame_rise) st_n = ST_FWD_INIT;
        ST_FWD_INIT: if (frame_rise && ecnt_q == E_LAST) st_n = ST_CMD_GAP;
        ST_CMD_GAP: begin
          if (cnt_q == G_LAST) begin
            st_n     = ST_RUN;
            fetch_go = 1'b1;
          end
        end
        default:     st_n = ST_RUN;
      endcase
    end
  end

  assign st_chg   = (st_n != st_q);
  assign enter_wf = st_chg && (st_n == ST_WFAULT);

  always_comb begin
    cnt_n = cnt_q;
    if (st_chg) begin
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_CF1_DLY, ST_CAPT, ST_CMD_GAP: cnt_n = cnt_q + 1'b1;
        ST_SYNC_C: begin
          if (cnt_q != '0)     cnt_n = cnt_q + 1'b1;
          else if (frame_rise) cnt_n = CW'(1);
        end
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_comb begin
    ecnt_n = ecnt_q;
    if (st_chg)                                ecnt_n = '0;
    else if (st_q == ST_FWD_INIT && frame_rise) ecnt_n = ecnt_q + 1'b1;
  end

  always_comb begin
    held_n = held_q;
    if (enter_wf)                                       held_n = 1'b0;
    else if (st_q == ST_WFAULT && req_s && frame_rise) held_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      ecnt_q <= '0;
      held_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      ecnt_q <= ecnt_n;
      held_q <= held_n;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/frs_regs.sv
module frs_regs #(
  parameter int          AW         = 64,
  parameter int unsigned VEC_OFS    = 32'h780,
  parameter logic [1:0]  ICEN_RECOV = 2'b11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_wf,
  input  logic          fetch_go,
  input  logic [AW-1:0] pc_in,
  input  logic          base_we,
  input  logic [AW-1:0] base_wd,
  output logic [1:0]    icache_en,
  output logic          fp_en,
  output logic          bcache_on,
  output logic [AW-1:0] exc_addr,
  output logic [AW-1:0] xbase_q,
  output logic          fetch_start,
  output logic [AW-1:0] fetch_addr
);
  localparam logic [AW-1:0] VEC = AW'(VEC_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icache_en <= 2'b00;
      fp_en     <= 1'b0;
      bcache_on <= 1'b1;
      exc_addr  <= '0;
    end else if (enter_wf) begin
      icache_en <= ICEN_RECOV;
      fp_en     <= 1'b1;
      bcache_on <= 1'b0;
      exc_addr  <= {pc_in[AW-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       xbase_q <= '0;
    else if (base_we) xbase_q <= base_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_start <= 1'b0;
    else        fetch_start <= fetch_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fetch_addr <= '0;
    else if (fetch_go) fetch_addr <= xbase_q + VEC;
  end
endmodule

// File: rtl/fault_rst_seq.sv
module fault_rst_seq
  import frs_pkg::*;
#(
  parameter int          AW       = 64,
  parameter int          DLY_A    = 264,
  parameter int          DLY_B    = 525,
  parameter int          DLY_G    = 264,
  parameter int          FWD_EDGS = 3,
  parameter int          SYNC_STG = 2,
  parameter int unsigned VEC_OFS  = 32'h780
) (
  input  logic          clk_core,
  input  logic          rst_n,
  input  logic          frame_clk,
  input  logic          rst_req,
  input  logic [AW-1:0] pc_in,
  input  logic          base_we,
  input  logic [AW-1:0] base_wd,
  output logic          busy,
  output logic          fwd_init,
  output logic [1:0]    icache_en,
  output logic          fp_en,
  output logic          bcache_on,
  output logic [AW-1:0] exc_addr,
  output logic          fetch_start,
  output logic [AW-1:0] fetch_addr
);
  logic          rst_core_n;
  logic          req_s;
  logic          frame_rise;
  logic          enter_wf;
  logic          fetch_go;
  logic [AW-1:0] xbase_q;
  frs_state_e    st;

  frs_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk_core),
    .arst_n(rst_n),
    .srst_n(rst_core_n)
  );

  frs_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk  (clk_core),
    .rst_n(rst_core_n),
    .d    (rst_req),
    .q    (req_s)
  );

  frs_edge #(.STAGES(SYNC_STG)) u_frame (
    .clk  (clk_core),
    .rst_n(rst_core_n),
    .d    (frame_clk),
    .rise (frame_rise)
  );

  frs_fsm #(
    .DLY_A   (DLY_A),
    .DLY_B   (DLY_B),
    .DLY_G   (DLY_G),
    .FWD_EDGS(FWD_EDGS)
  ) u_fsm (
    .clk       (clk_core),
    .rst_n     (rst_core_n),
    .req_s     (req_s),
    .frame_rise(frame_rise),
    .st        (st),
    .enter_wf  (enter_wf),
    .fetch_go  (fetch_go)
  );

  frs_regs #(
    .AW     (AW),
    .VEC_OFS(VEC_OFS)
  ) u_regs (
    .clk        (clk_core),
    .rst_n      (rst_core_n),
    .enter_wf   (enter_wf),
    .fetch_go   (fetch_go),
    .pc_in      (pc_in),
    .base_we    (base_we),
    .base_wd    (base_wd),
    .icache_en  (icache_en),
    .fp_en      (fp_en),
    .bcache_on  (bcache_on),
    .exc_addr   (exc_addr),
    .xbase_q    (xbase_q),
    .fetch_start(fetch_start),
    .fetch_addr (fetch_addr)
  );

  assign busy     = (st != ST_RUN);
  assign fwd_init = (st == ST_FWD_INIT);
endmodule

// File: rtl/frs_chk.sv
module frs_chk #(
  parameter int          AW      = 64,
  parameter int unsigned VEC_OFS = 32'h780
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_s,
  input logic          busy,
  input logic          fwd_init,
  input logic          fetch_start,
  input logic [AW-1:0] fetch_addr,
  input logic [AW-1:0] xbase_q,
  input logic [1:0]    icache_en,
  input logic          fp_en,
  input logic          bcache_on
);
  // R9
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> !fetch_start);

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (fetch_addr == $past(xbase_q) + AW'(VEC_OFS)));

  // R2
  recov_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (icache_en == 2'b11 && fp_en && !bcache_on));

  // R7
  fetch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> !busy);

  // R6
  fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_init |-> busy);

  // R8
  req_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |=> (!fwd_init && !fetch_start));
endmodule

bind fault_rst_seq frs_chk #(.AW(AW), .VEC_OFS(VEC_OFS)) chk_i (
  .clk        (clk_core),
  .rst_n      (rst_core_n),
  .req_s      (req_s),
  .busy       (busy),
  .fwd_init   (fwd_init),
  .fetch_start(fetch_start),
  .fetch_addr (fetch_addr),
  .xbase_q    (xbase_q),
  .icache_en  (icache_en),
  .fp_en      (fp_en),
  .bcache_on  (bcache_on)
);

// File: tb/fault_rst_seq_tb_top.sv
`timescale 1ns/1ps
module fault_rst_seq_tb_top;
  localparam int DA = 264;
  localparam int DB = 525;
  localparam int DG = 264;
  localparam int FH = 5;
  localparam logic [63:0] VEC = 64'h780;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_clk = 1'b0;
  logic        rst_req = 1'b0;
  logic [63:0] pc_in = 64'h0;
  logic        base_we = 1'b0;
  logic [63:0] base_wd = 64'h0;
  logic        busy, fwd_init, fp_en, bcache_on, fetch_start;
  logic [1:0]  icache_en;
  logic [63:0] exc_addr, fetch_addr;

  int n_chk = 0;
  int n_fail = 0;
  int n_fetch = 0;
  int fwd_run = 0;
  int fwd_last = 0;
  int fs_run = 0;
  int fs_max = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_rst_seq dut_i (
    .clk_core(clk), .rst_n(rst_n), .frame_clk(frame_clk), .rst_req(rst_req),
    .pc_in(pc_in), .base_we(base_we), .base_wd(base_wd), .busy(busy),
    .fwd_init(fwd_init), .icache_en(icache_en), .fp_en(fp_en),
    .bcache_on(bcache_on), .exc_addr(exc_addr), .fetch_start(fetch_start),
    .fetch_addr(fetch_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // framing clock, toggled on core falling edges
  int fcnt = 0;
  always @(negedge clk) begin
    if (fcnt == FH - 1) begin
      fcnt = 0;
      frame_clk = ~frame_clk;
    end else begin
      fcnt++;
    end
  end

  // behavioural reference model
  int m_st, m_cnt, m_ecnt;
  bit m_held, m_fs, m_fp, m_bc;
  logic [1:0]  m_ic;
  logic [63:0] m_base, m_exc, m_fa;
  bit mr0, mr1, mf0, mf1, mf2, mrs0, mrs1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ecnt = 0; m_held = 0; m_fs = 0;
      m_fp = 0; m_bc = 1; m_ic = 2'b00; m_base = '0; m_exc = '0; m_fa = '0;
      mr0 = 0; mr1 = 0; mf0 = 0; mf1 = 0; mf2 = 0; mrs0 = 0; mrs1 = 0;
    end else begin
      if (mrs1) begin
        bit rq, fr, go, timed;
        int nst;
        rq = mr1;
        fr = mf1 && !mf2;
        go = 0;
        nst = m_st;
        timed = (m_st == 2 || (m_st >= 5 && m_st <= 9));
        if (rq && timed) nst = 1;
        else case (m_st)
          0: if (rq) nst = 1;
          1: if (!rq && m_held) nst = 2;
          2: if (m_cnt == DA - 1) nst = 3;
          3: if (rq) nst = 4;
          4: if (!rq) nst = 5;
          5: if (m_cnt == DB - 1) nst = 6;
          6: if (m_cnt == 2) nst = 7;
          7: if (fr) nst = 8;
          8: if (fr && m_ecnt == 2) nst = 9;
          9: if (m_cnt == DG - 1) begin nst = 0; go = 1; end
          default: nst = 0;
        endcase
        if (nst != m_st) begin
          m_cnt = 0; m_ecnt = 0;
        end else begin
          if (m_st == 2 || m_st == 5 || m_st == 9) m_cnt++;
          else if (m_st == 6) begin
            if (m_cnt != 0) m_cnt++;
            else if (fr) m_cnt = 1;
          end
          if (m_st == 8 && fr) m_ecnt++;
        end
        if (nst == 1 && m_st != 1) begin
          m_held = 0;
          m_ic = 2'b11; m_fp = 1; m_bc = 0;
          m_exc = {pc_in[63:2], 2'b00};
        end else if (m_st == 1 && rq && fr) begin
          m_held = 1;
        end
        m_fs = go;
        if (go) m_fa = m_base + VEC;
        if (base_we) m_base = base_wd;
        m_st = nst;
        mr1 = mr0; mr0 = rst_req;
        mf2 = mf1; mf1 = mf0; mf0 = frame_clk;
      end
      mrs1 = mrs0;
      mrs0 = 1;
    end
  end

  // per-cycle comparison and event monitors
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ok;
      ok = 1;
      if (busy !== (m_st != 0)) begin ok = 0; $display("FAIL R5 busy: actual %0b expected %0b", busy, m_st != 0); end
      if (fwd_init !== (m_st == 8)) begin ok = 0; $display("FAIL R6 fwd_init: actual %0b expected %0b", fwd_init, m_st == 8); end
      if (fetch_start !== m_fs) begin ok = 0; $display("FAIL R7 fetch_start: actual %0b expected %0b", fetch_start, m_fs); end
      if (fetch_addr !== m_fa) begin ok = 0; $display("FAIL R3 fetch_addr: actual %h expected %h", fetch_addr, m_fa); end
      if (icache_en !== m_ic || fp_en !== m_fp || bcache_on !== m_bc) begin
        ok = 0;
        $display("FAIL R2 ctl: actual %b%b%b expected %b%b%b", icache_en, fp_en, bcache_on, m_ic, m_fp, m_bc);
      end
      if (exc_addr !== m_exc) begin ok = 0; $display("FAIL R8 exc_addr: actual %h expected %h", exc_addr, m_exc); end
      n_chk++;
      if (!ok) n_fail++;
      if (fetch_start) begin n_fetch++; fs_run++; if (fs_run > fs_max) fs_max = fs_run; end
      else fs_run = 0;
      if (fwd_init) fwd_run++;
      else if (fwd_run != 0) begin fwd_last = fwd_run; fwd_run = 0; end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req_pulse(input int n);
    @(negedge clk); rst_req = 1'b1;
    cyc(n);
    rst_req = 1'b0;
  endtask

  task automatic wr_base(input logic [63:0] v);
    @(negedge clk); base_we = 1'b1; base_wd = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic wait_fetch(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fetch_start) begin seen = 1; break; end
    end
  endtask

  // second pulse after the DLY_A wait, then wait for fetch
  task automatic finish_seq(input logic [63:0] base, input string tag);
    bit seen;
    int f0;
    f0 = n_fetch;
    cyc(DA + 20);
    req_pulse(12);
    wait_fetch(seen);
    chk(seen, "R7", {tag, " fetch seen"}, 64'(seen), 64'd1);
    chk(fetch_addr == base + VEC, "R3", {tag, " fetch address"}, fetch_addr, base + VEC);
    cyc(3);
    chk(n_fetch == f0 + 1, "R9", {tag, " single pulse"}, 64'(n_fetch - f0), 64'd1);
    chk(!busy, "R7", {tag, " idle after fetch"}, 64'(busy), 64'd0);
    chk(fetch_addr == base + VEC, "R9", {tag, " address held"}, fetch_addr, base + VEC);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] b1, b2;
    b1 = 64'h1000_0000_0000_2000;
    b2 = 64'h0000_0042_8000_0000;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk(!busy && !fwd_init && !fetch_start, "R1", "idle flags", {61'd0, busy, fwd_init, fetch_start}, 64'd0);
    chk(icache_en == 2'b00 && !fp_en && bcache_on, "R1", "ctl regs", {61'd0, icache_en, fp_en}, 64'd0);
    chk(exc_addr == 0 && fetch_addr == 0, "R1", "addresses", exc_addr | fetch_addr, 64'd0);

    // normal sequence
    wr_base(b1);
    pc_in = 64'h0000_ABCD_0000_1237;
    req_pulse(20);
    chk(busy, "R2", "busy on request", 64'(busy), 64'd1);
    chk(icache_en == 2'b11 && fp_en && !bcache_on, "R2", "recovery values",
        {61'd0, icache_en, fp_en}, 64'd7);
    chk(exc_addr == 64'h0000_ABCD_0000_1234, "R2", "exc_addr capture", exc_addr, 64'h0000_ABCD_0000_1234);
    pc_in = 64'h0000_0000_0000_5555;
    cyc(100);
    chk(busy && !fwd_init, "R5", "waiting in first delay", {62'd0, busy, fwd_init}, 64'd2);
    finish_seq(b1, "normal");
    chk(fwd_last == 3 * 2 * FH, "R6", "forwarding window length", 64'(fwd_last), 64'(3 * 2 * FH));
    chk(fs_max == 1, "R9", "pulse width", 64'(fs_max), 64'd1);

    // too-short first pulse, aligned after a framing fall
    @(negedge frame_clk);
    @(negedge clk);
    rst_req = 1'b1;
    cyc(3);
    rst_req = 1'b0;
    cyc(DA + 200);
    chk(busy && n_fetch == 1, "R4", "short pulse ignored", {62'd0, busy, 1'b0} | 64'(n_fetch), 64'd3);
    wr_base(b2);
    req_pulse(20);
    finish_seq(b2, "after short");
    chk(exc_addr == 64'h0000_0000_0000_5554, "R3", "exc kept from first entry", exc_addr, 64'h5554);

    // abort during capture window
    pc_in = 64'h0000_0000_0000_1001;
    req_pulse(20);
    cyc(DA + 20);
    req_pulse(12);
    cyc(100);
    pc_in = 64'h0000_7777_0000_000B;
    req_pulse(20);
    chk(exc_addr == 64'h0000_7777_0000_0008, "R8", "exc recaptured on abort", exc_addr, 64'h0000_7777_0000_0008);
    chk(busy && n_fetch == 2, "R8", "no fetch after abort", 64'(n_fetch), 64'd2);
    finish_seq(b2, "capture abort");

    // abort during forwarding window
    req_pulse(20);
    cyc(DA + 20);
    req_pulse(12);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (fwd_init) break;
    end
    chk(fwd_init, "R6", "forwarding window reached", 64'(fwd_init), 64'd1);
    cyc(4);
    rst_req = 1'b1;
    cyc(4);
    chk(!fwd_init && busy, "R8", "forwarding aborted", {62'd0, busy, fwd_init}, 64'd2);
    cyc(16);
    rst_req = 1'b0;
    finish_seq(b2, "forward abort");

    cyc(10);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule